// File: doc/BRIEF.md
# External Bus Acknowledge Timeout Monitor

This block watches external bus accesses that finish only when the addressed device drives a transfer acknowledge. It runs on the external bus clock. When an access of that kind starts, a counter begins measuring how long the bus has waited. Each acknowledged beat of a burst reloads the counter. If the programmed number of cycles passes with no acknowledge, the block sends a one-cycle abort pulse to the access sequencer. It also sets a sticky error flag that software clears by writing a one.

Accesses that end through internal wait-state counting are not watched. Monitoring happens only while the enable input is high. Dropping the enable in the middle of an access ends the watch at once and raises no error. The timeout value is a plain input that the surrounding control register drives.

Top module: `bus_ack_watchdog`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `tmo_abort` and `tmo_flag` are both 0.
- R2: An access is watched when, at a clock edge, `acc_start`=1, `acc_ext_ack`=1 and `mon_en`=1. With limit L on `tmo_limit`, suppose no edge from the 1st to the (L+1)th after the start samples `ack_in`=1 or `acc_done`=1. Then `tmo_abort` is 1 for exactly the one cycle after edge L+1. With L=0, it is 1 right after the first edge.
- R3: An edge that samples `ack_in`=1 during a watched access starts the waiting window again from zero. A burst whose beats are each acknowledged within L+1 cycles never times out.
- R4: An edge that samples `acc_done`=1 ends the watched access. No abort follows it, however long the bus stays idle.
- R5: An access that starts with `acc_ext_ack`=0 (internal wait-state termination) is ignored. It produces no abort and leaves the flag unchanged.
- R6: An access that starts while `mon_en`=0 is not watched. Taking `mon_en` to 0 during a watched access ends the watch at that edge, and no abort or flag follows. The watch does not resume when `mon_en` returns to 1.
- R7: Every timeout sets `tmo_flag` in the same cycle that `tmo_abort` goes high. The flag then stays 1 until an edge samples `err_clr`=1, which clears it. `err_clr`=0 has no effect.
- R8: When a timeout and `err_clr`=1 fall on the same edge, `tmo_flag` is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_en | input | 1 | Monitor enable |
| tmo_limit | input | CNT_W | Maximum number of cycles to wait for an acknowledge |
| acc_start | input | 1 | First cycle of a new external access |
| acc_ext_ack | input | 1 | The starting access is terminated by external acknowledge |
| ack_in | input | 1 | External transfer acknowledge, one per beat |
| acc_done | input | 1 | The current access has completed |
| err_clr | input | 1 | Write-one-to-clear strobe for the error flag |
| tmo_abort | output | 1 | One-cycle pulse that ends the access with an error |
| tmo_flag | output | 1 | Sticky timeout error status |

## Verification
A timeout that sets the flag can land on the same edge as a software write that clears it. The bench triggers this by holding `err_clr` high for exactly the cycle in which the window runs out, so the timeout edge samples both. The flag must read 1 after that edge and stay 1 once the clear is removed. Only a later clear on its own may bring it to 0. A second collision is an acknowledge on the last allowed cycle. The bench checks that this acknowledge reloads the window and prevents the abort.

// File: rtl/bus_ack_watchdog.sv
module bus_ack_watchdog #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mon_en,
  input  logic [CNT_W-1:0] tmo_limit,
  input  logic             acc_start,
  input  logic             acc_ext_ack,
  input  logic             ack_in,
  input  logic             acc_done,
  input  logic             err_clr,
  output logic             tmo_abort,
  output logic             tmo_flag
);

  logic             busy;
  logic [CNT_W-1:0] wait_cnt;
  logic             expire;
  logic             watch_start;

  assign watch_start = mon_en && acc_start && acc_ext_ack;
  assign expire      = busy && mon_en && !ack_in && !acc_done && (wait_cnt >= tmo_limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      wait_cnt  <= '0;
      tmo_abort <= 1'b0;
      tmo_flag  <= 1'b0;
    end else begin
      tmo_abort <= expire;
      tmo_flag  <= expire | (tmo_flag & ~err_clr);
      if (watch_start) begin
        busy     <= 1'b1;
        wait_cnt <= '0;
      end else if (!mon_en || acc_done || expire) begin
        busy     <= 1'b0;
      end else if (busy) begin
        wait_cnt <= ack_in ? '0 : wait_cnt + 1'b1;
      end
    end
  end

  // R7: a flag rise is always accompanied by an abort
  assert_flag_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> tmo_abort);

  // R7: abort implies flag
  assert_abort_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_abort |-> tmo_flag);

  // R7: flag holds without a clear
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !err_clr) |=> tmo_flag);

  // R6: no abort after an edge that saw the monitor disabled
  assert_no_abort_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!mon_en) |-> !tmo_abort);

  // R3: an acknowledged edge never produces an abort
  assert_ack_blocks_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ack_in) |-> !tmo_abort);

  // R4: a completing edge never produces an abort
  assert_done_blocks_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_done) |-> !tmo_abort);

  // R2: abort only comes from a watched access
  assert_abort_needs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_abort |-> $past(busy));

endmodule

// File: tb/test_bus_ack_watchdog.sv
module test_bus_ack_watchdog;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic mon_en, acc_start, acc_ext_ack, ack_in, acc_done, err_clr;
  logic [CNT_W-1:0] tmo_limit;
  logic tmo_abort, tmo_flag;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  bus_ack_watchdog #(.CNT_W(CNT_W)) i_bus_ack_watchdog (
    .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .tmo_limit(tmo_limit),
    .acc_start(acc_start), .acc_ext_ack(acc_ext_ack), .ack_in(ack_in),
    .acc_done(acc_done), .err_clr(err_clr), .tmo_abort(tmo_abort), .tmo_flag(tmo_flag)
  );

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic start_acc(logic ext);
    acc_start = 1'b1; acc_ext_ack = ext;
    tick();
    acc_start = 1'b0; acc_ext_ack = 1'b0;
  endtask

  task automatic clear_flag();
    err_clr = 1'b1; tick(); err_clr = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tick(); tick();
    check("R1", "abort in reset", tmo_abort, 1'b0);
    check("R1", "flag in reset", tmo_flag, 1'b0);
    rst_n = 1'b1; tick();
    check("R1", "abort after reset", tmo_abort, 1'b0);
    check("R1", "flag after reset", tmo_flag, 1'b0);
  endtask

  task automatic t_timeout(int lim);
    tmo_limit = lim[CNT_W-1:0];
    start_acc(1'b1);
    for (int k = 1; k <= lim; k++) begin
      tick();
      check("R2", "abort before window end", tmo_abort, 1'b0);
    end
    tick();
    check("R2", "abort at window end", tmo_abort, 1'b1);
    check("R7", "flag with abort", tmo_flag, 1'b1);
    tick();
    check("R2", "abort single cycle", tmo_abort, 1'b0);
    for (int k = 0; k < 4; k++) tick();
    check("R2", "no repeat abort", tmo_abort, 1'b0);
    check("R7", "flag sticky", tmo_flag, 1'b1);
  endtask

  task automatic t_burst();
    tmo_limit = 8'd2;
    start_acc(1'b1);
    for (int b = 0; b < 5; b++) begin
      tick();
      check("R3", "no abort between beats", tmo_abort, 1'b0);
      tick();
      check("R3", "no abort between beats", tmo_abort, 1'b0);
      ack_in = 1'b1; tick(); ack_in = 1'b0;
      check("R3", "no abort on beat", tmo_abort, 1'b0);
    end
    acc_done = 1'b1; tick(); acc_done = 1'b0;
    for (int k = 0; k < 8; k++) begin
      tick();
      check("R4", "no abort after completion", tmo_abort, 1'b0);
    end
    check("R4", "flag untouched by burst", tmo_flag, 1'b0);
  endtask

  task automatic t_internal();
    tmo_limit = 8'd1;
    start_acc(1'b0);
    for (int k = 0; k < 6; k++) begin
      tick();
      check("R5", "internal access ignored", tmo_abort, 1'b0);
    end
    check("R5", "flag untouched", tmo_flag, 1'b0);
  endtask

  task automatic t_enable();
    tmo_limit = 8'd2;
    mon_en = 1'b0;
    start_acc(1'b1);
    mon_en = 1'b1;
    for (int k = 0; k < 6; k++) begin
      tick();
      check("R6", "start while disabled ignored", tmo_abort, 1'b0);
    end
    start_acc(1'b1);
    tick();
    mon_en = 1'b0; tick();
    mon_en = 1'b1;
    for (int k = 0; k < 6; k++) begin
      tick();
      check("R6", "disabled mid access", tmo_abort, 1'b0);
    end
    check("R6", "no flag after disable", tmo_flag, 1'b0);
  endtask

  task automatic t_sticky_clear();
    check("R7", "flag set before clear", tmo_flag, 1'b1);
    tick();
    check("R7", "err_clr 0 no effect", tmo_flag, 1'b1);
    clear_flag();
    check("R7", "flag cleared", tmo_flag, 1'b0);
  endtask

  task automatic t_collision();
    tmo_limit = 8'd3;
    start_acc(1'b1);
    for (int k = 1; k <= 3; k++) tick();
    err_clr = 1'b1; tick(); err_clr = 1'b0;
    check("R8", "abort on collision", tmo_abort, 1'b1);
    check("R8", "flag set despite clear", tmo_flag, 1'b1);
    tick();
    check("R8", "flag still set", tmo_flag, 1'b1);
    clear_flag();
    check("R7", "later clear works", tmo_flag, 1'b0);
  endtask

  task automatic t_last_ack();
    tmo_limit = 8'd3;
    start_acc(1'b1);
    for (int k = 1; k <= 3; k++) tick();
    ack_in = 1'b1; tick(); ack_in = 1'b0;
    check("R3", "ack on last cycle avoids abort", tmo_abort, 1'b0);
    for (int k = 1; k <= 3; k++) tick();
    check("R3", "window restarted", tmo_abort, 1'b0);
    tick();
    check("R3", "abort after reloaded window", tmo_abort, 1'b1);
    clear_flag();
  endtask

  initial begin
    rst_n = 1'b0; mon_en = 1'b1; tmo_limit = '0; acc_start = 1'b0; acc_ext_ack = 1'b0;
    ack_in = 1'b0; acc_done = 1'b0; err_clr = 1'b0;
    tick();
    t_reset();
    t_timeout(3);
    t_sticky_clear();
    t_timeout(0);
    clear_flag();
    t_burst();
    t_internal();
    t_enable();
    t_collision();
    t_last_ack();
    t_timeout(7);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule